// File: doc/BRIEF.md
# CAS Latency Read Data Pipeline

This block reproduces the read-return timing of a synchronous DRAM data port. A read strobe and the word fetched from the array enter on the same rising edge. After a programmable number of clocks the word appears on a registered output with a valid flag. A separate output-enable models the interval during which the data pins are driven. Its rising edge comes one clock ahead of the data, and it stays high until the data ends.

The latency is either two or three clocks. It is requested through a small configuration input made of a latency code and a two-bit operating-mode field. A request takes effect only when the mode field is zero, the code is legal and the pipeline holds no read. Any other request is refused and reported on an error flag. A read may be issued on every clock. Data comes back in issue order, one word per read, and the spacing between reads is kept.

Top module: `cas_rdpipe`

## Requirements
- R1: After reset the active latency is 2. With `cfg_mode` equal to 2'b00, code 3'd2 on `cfg_lat` selects latency 2 and code 3'd3 selects latency 3. A legal request to change latency, made while idle, is taken at that edge and leaves `cfg_err` low.
- R2: A read registered at edge n with active latency m makes `dq_valid` high and `dq_out` equal to that read's `rd_data` in the cycle that follows edge n+m.
- R3: For that read, `dq_oe` is already high in the cycle that follows edge n+m-1, one cycle before the data is valid.
- R4: Reads on consecutive edges return in issue order, each at the same latency. `dq_valid` stays high without a gap for as many cycles as there were reads in the run.
- R5: `dq_oe` is high in every cycle in which `dq_valid` is high, and in the cycle before each such cycle. It is low at all other times, so across back-to-back reads it stays high, and it falls at the edge that ends the last valid beat.
- R6: A latency code other than 3'd2 or 3'd3 raises `cfg_err` in the cycle after the edge that samples it, and the active latency does not change.
- R7: A non-zero `cfg_mode` raises `cfg_err` in the same way, and no latency is loaded, whatever the code.
- R8: A legal request that differs from the active latency is refused at any edge that registers a read, and at any edge whose active latency m leaves a read from one of the previous m edges still in flight. At such an edge `cfg_err` is raised and the latency is kept. The request is taken at the first edge after the pipeline empties.
- R9: A synchronous reset clears `dq_valid`, `dq_oe`, `dq_out` and `cfg_err` at the next edge. It drops every read in flight, so none of them ever returns, and it sets the active latency back to 2.
- R10: `dq_out` is all zeros whenever `dq_valid` is low. `rd_data` that arrives without a read strobe never reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Operating-mode field; 2'b00 is normal operation |
| cfg_lat | input | 3 | Requested latency code (3'd2 or 3'd3) |
| rd_cmd | input | 1 | Read strobe for this edge |
| rd_data | input | DW | Array word that belongs to the read on this edge |
| dq_out | output | DW | Returned read data, zero when not valid |
| dq_valid | output | 1 | `dq_out` holds a returned word |
| dq_oe | output | 1 | Data pins driven |
| cfg_err | output | 1 | Configuration request refused at the previous edge |

## Verification
A read registered at edge n with latency m must show `dq_oe` after edge n+m-1 and `dq_valid` with its data after edge n+m. A configuration request is judged at the edge that samples it, and `cfg_err` answers in the cycle that follows. Every scenario drives its inputs on the falling edge and samples on the next falling edge, so each observation slot matches exactly one rising edge. For each slot the bench builds an expected timeline of valid, enable and data from the requirement formulas. It never uses the design's state for this. For latency changes it counts the rising edges over which the pipeline stays busy, checks the error flag slot by slot, and then confirms the new latency with a fresh read.

// File: rtl/cas_rdpipe_pkg.sv
package cas_rdpipe_pkg;

  localparam int MAX_LAT   = 3;
  localparam int CODE_W    = 3;
  localparam int MODE_W    = 2;
  localparam logic [MODE_W-1:0] MODE_NORMAL = '0;

  typedef enum logic [1:0] {
    CL2 = 2'd2,
    CL3 = 2'd3
  } cas_lat_e;

  function automatic logic lat_code_legal(input logic [CODE_W-1:0] code);
    return (code == CODE_W'(2)) || (code == CODE_W'(3));
  endfunction

endpackage

// File: rtl/cas_lat_cfg.sv
module cas_lat_cfg
  import cas_rdpipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [CODE_W-1:0] req_code,
  input  logic              rd_cmd,
  input  logic              busy,
  output cas_lat_e          lat,
  output logic              cfg_err
);

  logic     req_ok;
  logic     differs;
  logic     blocked;
  cas_lat_e req_lat;

  always_comb begin
    req_ok  = (req_mode == MODE_NORMAL) && lat_code_legal(req_code);
    req_lat = cas_lat_e'(req_code[1:0]);
    differs = req_ok && (req_lat != lat);
    blocked = busy || rd_cmd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat     <= CL2;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= !req_ok || (differs && blocked);
      if (differs && !blocked) begin
        lat <= req_lat;
      end
    end
  end

  // R1: active latency only ever holds a legal setting
  a_r1_lat_legal: assert property (@(posedge clk) disable iff (rst)
    (lat == CL2) || (lat == CL3));

  // R8: latency never moves while reads are in flight
  a_r8_hold_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(lat));

endmodule

// File: rtl/cas_shift_pipe.sv
module cas_shift_pipe #(
  parameter int DW    = 16,
  parameter int DEPTH = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_v,
  input  logic [DW-1:0]           in_d,
  output logic [DEPTH-1:0]        st_v,
  output logic [DEPTH-1:0][DW-1:0] st_d
);

  always_ff @(posedge clk) begin
    if (rst) st_v[0] <= 1'b0;
    else     st_v[0] <= in_v;
  end

  always_ff @(posedge clk) begin
    st_d[0] <= in_d;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st_v[i] <= 1'b0;
      else     st_v[i] <= st_v[i-1];
    end
    always_ff @(posedge clk) begin
      st_d[i] <= st_d[i-1];
    end
  end

endmodule

// File: rtl/cas_out_stage.sv
module cas_out_stage
  import cas_rdpipe_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  cas_lat_e                 lat,
  input  logic [DEPTH-1:0]         st_v,
  input  logic [DEPTH-1:0][DW-1:0] st_d,
  output logic                     dq_valid,
  output logic                     dq_oe,
  output logic [DW-1:0]            dq_out
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IW-1:0] hi_idx;
  logic [IW-1:0] lo_idx;
  logic          nxt_v;
  logic          pre_v;
  logic [DW-1:0] nxt_d;

  always_comb begin
    hi_idx = IW'(lat) - IW'(1);
    lo_idx = IW'(lat) - IW'(2);
    nxt_v  = st_v[hi_idx];
    pre_v  = st_v[lo_idx];
    nxt_d  = st_d[hi_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_valid <= 1'b0;
      dq_oe    <= 1'b0;
      dq_out   <= '0;
    end else begin
      dq_valid <= nxt_v;
      dq_oe    <= nxt_v || pre_v;
      dq_out   <= nxt_v ? nxt_d : '0;
    end
  end

  // R3: enable was up in the cycle before data turns valid
  a_r3_oe_leads: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_valid) |-> $past(dq_oe));

  // R5: enable covers every valid beat
  a_r5_oe_covers: assert property (@(posedge clk) disable iff (rst)
    dq_valid |-> dq_oe);

  // R10: no data leaks out without the valid flag
  a_r10_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !dq_valid |-> (dq_out == '0));

endmodule

// File: rtl/cas_rdpipe.sv
module cas_rdpipe
  import cas_rdpipe_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [CODE_W-1:0] cfg_lat,
  input  logic              rd_cmd,
  input  logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     dq_out,
  output logic              dq_valid,
  output logic              dq_oe,
  output logic              cfg_err
);

  localparam int DEPTH = MAX_LAT;

  cas_lat_e                 lat;
  logic                     busy;
  logic [DEPTH-1:0]         st_v;
  logic [DEPTH-1:0][DW-1:0] st_d;

  always_comb begin
    busy = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(lat)) busy = busy | st_v[i];
    end
  end

  cas_lat_cfg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .req_mode (cfg_mode),
    .req_code (cfg_lat),
    .rd_cmd   (rd_cmd),
    .busy     (busy),
    .lat      (lat),
    .cfg_err  (cfg_err)
  );

  cas_shift_pipe #(.DW(DW), .DEPTH(DEPTH)) u_pipe (
    .clk  (clk),
    .rst  (rst),
    .in_v (rd_cmd),
    .in_d (rd_data),
    .st_v (st_v),
    .st_d (st_d)
  );

  cas_out_stage #(.DW(DW), .DEPTH(DEPTH)) u_out (
    .clk      (clk),
    .rst      (rst),
    .lat      (lat),
    .st_v     (st_v),
    .st_d     (st_d),
    .dq_valid (dq_valid),
    .dq_oe    (dq_oe),
    .dq_out   (dq_out)
  );

  // R2: latency-2 read shows up valid after the second following edge
  a_r2_lat2_due: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && lat == CL2) |-> ##3 dq_valid);

  // R2: latency-3 read shows up valid after the third following edge
  a_r2_lat3_due: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && lat == CL3) |-> ##4 dq_valid);

endmodule

// File: tb/cas_rdpipe_tb.sv
module cas_rdpipe_tb;

  localparam int DW    = 16;
  localparam int SLOTS = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_mode = 2'b00;
  logic [2:0]    cfg_lat  = 3'd2;
  logic          rd_cmd   = 1'b0;
  logic [DW-1:0] rd_data  = '0;
  logic [DW-1:0] dq_out;
  logic          dq_valid;
  logic          dq_oe;
  logic          cfg_err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cas_rdpipe #(.DW(DW)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .cfg_mode (cfg_mode),
    .cfg_lat  (cfg_lat),
    .rd_cmd   (rd_cmd),
    .rd_data  (rd_data),
    .dq_out   (dq_out),
    .dq_valid (dq_valid),
    .dq_oe    (dq_oe),
    .cfg_err  (cfg_err)
  );

  task automatic check(input logic ok, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word(input int k, input int seed);
    return DW'(seed * 256 + k * 17 + 3);
  endfunction

  // drive a read pattern (bit k = read at edge k) and compare every slot
  task automatic run_pattern(input logic [15:0] pat, input int m, input int seed,
                             input string tag);
    logic          ev  [SLOTS];
    logic          eoe [SLOTS];
    logic [DW-1:0] ed  [SLOTS];
    for (int j = 0; j < SLOTS; j++) begin ev[j] = 1'b0; ed[j] = '0; end
    for (int k = 0; k < 16; k++) begin
      if (pat[k]) begin ev[k+m] = 1'b1; ed[k+m] = word(k, seed); end
    end
    for (int j = 0; j < SLOTS; j++) begin
      eoe[j] = ev[j] | ((j + 1 < SLOTS) ? ev[j+1] : 1'b0);
    end
    for (int j = 0; j < SLOTS; j++) begin
      rd_cmd  = (j < 16) ? pat[j] : 1'b0;
      rd_data = rd_cmd ? word(j, seed) : 16'hDEAD;
      @(posedge clk);
      @(negedge clk);
      check(dq_valid === ev[j], $sformatf("%s valid slot %0d", tag, j), int'(dq_valid), int'(ev[j]));
      check(dq_oe === eoe[j], $sformatf("%s R5 oe slot %0d", tag, j), int'(dq_oe), int'(eoe[j]));
      check(dq_out === ed[j], $sformatf("%s R10 data slot %0d", tag, j), int'(dq_out), int'(ed[j]));
    end
    rd_cmd = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] md, input logic [2:0] code,
                         input logic exp_err, input string tag);
    cfg_mode = md;
    cfg_lat  = code;
    @(posedge clk);
    @(negedge clk);
    check(cfg_err === exp_err, $sformatf("%s cfg_err", tag), int'(cfg_err), int'(exp_err));
  endtask

  task automatic t_reset_state();
    check(dq_valid === 1'b0, "R9 reset valid", int'(dq_valid), 0);
    check(dq_oe === 1'b0, "R9 reset oe", int'(dq_oe), 0);
    check(dq_out === '0, "R9 reset data", int'(dq_out), 0);
    check(cfg_err === 1'b0, "R9 reset cfg_err", int'(cfg_err), 0);
  endtask

  // R8: change requested while one read is in flight at latency 3
  task automatic t_change_in_flight();
    logic exp_err [5];
    exp_err = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    for (int j = 0; j < 5; j++) begin
      rd_cmd  = (j == 0);
      rd_data = (j == 0) ? 16'h5A5A : 16'hDEAD;
      if (j == 1) cfg_lat = 3'd2;
      @(posedge clk);
      @(negedge clk);
      check(cfg_err === exp_err[j], $sformatf("R8 busy err slot %0d", j), int'(cfg_err), int'(exp_err[j]));
      check(dq_valid === (j == 3), $sformatf("R8 old latency valid slot %0d", j), int'(dq_valid), int'(j == 3));
    end
    check(dq_out === '0, "R8 data cleared after beat", int'(dq_out), 0);
    run_pattern(16'h0001, 2, 9, "R8 new latency");
  endtask

  // R9: reset in the middle of a latency-3 burst
  task automatic t_reset_flush();
    set_cfg(2'b00, 3'd3, 1'b0, "R9 pre");
    for (int j = 0; j < 2; j++) begin
      rd_cmd = 1'b1; rd_data = word(j, 11);
      @(posedge clk);
      @(negedge clk);
    end
    rd_cmd = 1'b0; rst = 1'b1; cfg_mode = 2'b11;
    @(posedge clk);
    @(negedge clk);
    check(dq_valid === 1'b0, "R9 flush valid", int'(dq_valid), 0);
    check(dq_oe === 1'b0, "R9 flush oe", int'(dq_oe), 0);
    check(cfg_err === 1'b0, "R9 flush cfg_err", int'(cfg_err), 0);
    rst = 1'b0;
    run_pattern(16'h0000, 2, 0, "R9 nothing returns");
    run_pattern(16'h0001, 2, 12, "R9 latency back to 2");
    set_cfg(2'b00, 3'd2, 1'b0, "R9 post");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    run_pattern(16'h0001, 2, 1, "R2 R3 single lat2");
    run_pattern(16'h000F, 2, 2, "R4 b2b lat2");
    run_pattern(16'h00B5, 2, 3, "R5 gaps lat2");
    set_cfg(2'b00, 3'd3, 1'b0, "R1 to lat3");
    run_pattern(16'h0001, 3, 4, "R1 R2 R3 single lat3");
    run_pattern(16'h00E7, 3, 5, "R4 b2b lat3");
    set_cfg(2'b00, 3'd5, 1'b1, "R6 reserved code");
    set_cfg(2'b00, 3'd3, 1'b0, "R6 restore");
    run_pattern(16'h0001, 3, 6, "R6 latency kept");
    set_cfg(2'b01, 3'd2, 1'b1, "R7 bad mode");
    set_cfg(2'b00, 3'd3, 1'b0, "R7 restore");
    run_pattern(16'h0003, 3, 7, "R7 latency kept");
    t_change_in_flight();
    t_reset_flush();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule